// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is an 8-bit general-purpose I/O port on a simple processor register bus. It holds two registers, each at its own bus address. The output latch sets the value the pins drive. The direction register decides, pin by pin, whether a pin drives or listens. A pin in input mode has its driver switched off. A pin in output mode drives from its latch bit.

The four lowest pins act as open-drain drivers: they can only pull low or let go. The four upper pins drive both high and low. An on-chip peripheral can take over any single pin through its override enable. While it holds a pin, the peripheral sets that pin's value and enable, and a read of that pin's bit returns the pin level.

Incoming pin levels pass through a two-stage synchronizer before they reach the read path. Reset clears the direction register only. The output latch keeps its contents across reset, so software can preload it before it turns pins into outputs.

Top module: `gpio_port`

## Requirements
- R1: The output latch is at bus address 0x01 and the direction register is at bus address 0x05. A write takes effect on the rising clock edge where `bus_wr` is high and `bus_addr` matches one of these addresses. A read of 0x05 returns the direction register.
- R2: A read of any address other than 0x01 or 0x05 returns 0x00. A write to such an address changes neither register.
- R3: A read of 0x01 returns, for each bit, the latch bit when that bit's direction is 1 and its override is off. Otherwise it returns the synchronized pin level.
- R4: The synchronized pin level seen by reads is the `pin_in` value sampled two rising edges earlier. The synchronizer stages clear to 0 during reset.
- R5: While `rst` is high at a rising edge, the direction register becomes 0x00. After that, `pin_oe` is 0 on every pin whose override is off.
- R6: Reset leaves the output latch unchanged. A write to 0x01 during reset still loads the latch.
- R7: A write to 0x01 always loads the latch. A bit whose direction is 0 keeps `pin_oe` at 0, and its read bit keeps showing the pin level.
- R8: Pins 7 to 4, with the override off, are push-pull: `pin_oe` equals the direction bit and `pin_out` equals the latch bit.
- R9: Pins 3 to 0, with the override off, are open-drain: `pin_out` is 0, and `pin_oe` is 1 only when the direction bit is 1 and the latch bit is 0.
- R10: While `alt_en[i]` is 1, `pin_out[i]` equals `alt_out[i]` and `pin_oe[i]` equals `alt_oe[i]`, on both pin types. Read bit i then returns the synchronized pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears only the direction register and the synchronizer |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Levels present at the pins |
| pin_out | output | 8 | Value driven onto each pin while its enable is high |
| pin_oe | output | 8 | Per-pin driver enable; 0 means high impedance |
| alt_en | input | 8 | Per-pin peripheral takeover |
| alt_out | input | 8 | Peripheral drive value |
| alt_oe | input | 8 | Peripheral drive enable |

## Verification
Two events can land in the same cycle. A bus write to the output latch can coincide with a read of the data address. Separately, a direction change can coincide with a pin toggle still passing through the synchronizer. Both cases are provoked by the directed phases and by a random phase that leaves `bus_wr` high for several cycles. Each cycle, a behavioural model picks latch or pin bit by bit from its own copy of direction and the two delayed pin samples. The bench then compares that choice with `bus_rdata`, `pin_out` and `pin_oe`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int OD_PINS = 4;

    localparam logic [ADDR_W-1:0] ADDR_LATCH = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 8'h05;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_LATCH = 2'd1,
        RSEL_DIR   = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] val;
        logic [PORT_W-1:0] oe;
    } pad_drive_t;

    function automatic rd_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_LATCH)    return RSEL_LATCH;
        else if (a == ADDR_DIR) return RSEL_DIR;
        else                    return RSEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assign q = stage2;

    AST_SYNC_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (q == $past(d, 2))); // R4

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);
    rd_sel_e sel;
    assign sel = decode_addr(addr);

    // Output latch: deliberately no reset term.
    always_ff @(posedge clk) begin
        if (wr && sel == RSEL_LATCH) latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                       dir_q <= '0;
        else if (wr && sel == RSEL_DIR) dir_q <= wdata;
    end

    AST_DIR_CLEARED: assert property (@(posedge clk)
        rst |=> (dir_q == '0)); // R5
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == ADDR_DIR) |=> $stable(dir_q)); // R2

endmodule

// File: rtl/gpio_pad.sv
module gpio_pad
    import gpio_port_pkg::*;
#(
    parameter int W    = PORT_W,
    parameter int OD_N = OD_PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output pad_drive_t   drv
);
    logic [W-1:0] own_val;
    logic [W-1:0] own_oe;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i < OD_N) begin : g_od
            assign own_val[i] = 1'b0;
            assign own_oe[i]  = dir[i] & ~latch[i];
        end else begin : g_pp
            assign own_val[i] = latch[i];
            assign own_oe[i]  = dir[i];
        end
        assign drv.val[i] = alt_en[i] ? alt_out[i] : own_val[i];
        assign drv.oe[i]  = alt_en[i] ? alt_oe[i]  : own_oe[i];
    end

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((drv.oe[OD_N-1:0] & drv.val[OD_N-1:0] & ~alt_en[OD_N-1:0]) == '0)); // R9

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W    = PORT_W,
    parameter int AW   = ADDR_W,
    parameter int OD_N = OD_PINS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    input  logic [W-1:0]  alt_en,
    input  logic [W-1:0]  alt_out,
    input  logic [W-1:0]  alt_oe
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] read_own;
    pad_drive_t   drv;

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_pad #(.W(W), .OD_N(OD_N)) u_pad (
        .clk     (clk),
        .rst     (rst),
        .dir     (dir_q),
        .latch   (latch_q),
        .alt_en  (alt_en),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .drv     (drv)
    );

    assign pin_out = drv.val;
    assign pin_oe  = drv.oe;

    // Bits the CPU owns are read back from the latch; the rest from the pin.
    assign read_own = dir_q & ~alt_en;

    always_comb begin
        unique case (decode_addr(bus_addr))
            RSEL_LATCH: bus_rdata = (latch_q & read_own) | (pin_sync & ~read_own);
            RSEL_DIR:   bus_rdata = dir_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~dir_q & ~alt_en) == '0)); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_LATCH && bus_addr != ADDR_DIR) |-> (bus_rdata == '0)); // R2
    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_DIR) |-> (bus_rdata == dir_q)); // R1

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] alt_en = 8'h00;
    logic [7:0] alt_out = 8'h00;
    logic [7:0] alt_oe = 8'h00;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string phase = "R5 reset";

    // Reference state
    logic [7:0] m_dir = 8'h00;
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_known = 8'h00;
    logic [7:0] m_s1 = 8'h00;
    logic [7:0] m_s2 = 8'h00;

    always #10 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_en(alt_en),
        .alt_out(alt_out), .alt_oe(alt_oe)
    );

    always @(posedge clk) begin
        if (bus_wr && bus_addr == 8'h01) begin
            m_latch = bus_wdata;               // R6: also during reset
            m_known = 8'hFF;
        end
        if (rst) begin
            m_dir = 8'h00;
            m_s1  = 8'h00;
            m_s2  = 8'h00;
        end else begin
            if (bus_wr && bus_addr == 8'h05) m_dir = bus_wdata;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic cmp(input string what, input logic [7:0] act,
                       input logic [7:0] exp, input logic [7:0] mask);
        n_cmp++;
        if (((act ^ exp) & mask) != 8'h00) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h (mask %02h)",
                     phase, what, act, exp, mask);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] e_rd, e_out, e_oe, k_rd, k_out, k_oe;
            e_rd = 8'h00; k_rd = 8'hFF;
            e_out = 8'h00; k_out = 8'hFF;
            e_oe = 8'h00; k_oe = 8'hFF;
            for (int i = 0; i < 8; i++) begin
                if (bus_addr == 8'h01) begin
                    if (m_dir[i] && !alt_en[i]) begin
                        e_rd[i] = m_latch[i];
                        k_rd[i] = m_known[i];
                    end else begin
                        e_rd[i] = m_s2[i];
                    end
                end else if (bus_addr == 8'h05) begin
                    e_rd[i] = m_dir[i];
                end
                if (alt_en[i]) begin
                    e_out[i] = alt_out[i];
                    e_oe[i]  = alt_oe[i];
                end else if (i >= 4) begin
                    e_out[i] = m_latch[i];
                    k_out[i] = m_known[i];
                    e_oe[i]  = m_dir[i];
                end else begin
                    e_out[i] = 1'b0;
                    e_oe[i]  = m_dir[i] & ~m_latch[i];
                    k_oe[i]  = m_known[i] | ~m_dir[i];
                end
            end
            if (!rst) begin
                cmp("rdata", bus_rdata, e_rd, k_rd);
                cmp("pin_out", pin_out, e_out, k_out);
                cmp("pin_oe", pin_oe, e_oe, k_oe);
            end else begin
                cmp("pin_oe", pin_oe, e_oe, k_oe);
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #3_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        step(2);
        wr(8'h01, 8'h3C);                      // R6: latch load while in reset
        step(2);
        rst = 1'b0;
        phase = "R5 reset state";
        bus_addr = 8'h05; step(2);

        phase = "R7 write while input";
        pin_in = 8'hC3;
        wr(8'h01, 8'h5A);
        bus_addr = 8'h01; step(3);
        pin_in = 8'h0F; step(3);

        phase = "R4 sync delay";
        for (int i = 0; i < 8; i++) begin
            pin_in = 8'h01 << i; step();
        end

        phase = "R8 R9 all outputs";
        wr(8'h05, 8'hFF);
        foreach (pin_in[i]) ;
        wr(8'h01, 8'h0F); bus_addr = 8'h01; step();
        wr(8'h01, 8'hF0); bus_addr = 8'h01; step();
        wr(8'h01, 8'hA5); bus_addr = 8'h01; step();

        phase = "R3 mixed direction";
        wr(8'h05, 8'hC3);
        bus_addr = 8'h01;
        pin_in = 8'h99; step(3);
        pin_in = 8'h66; step(3);

        phase = "R2 unmapped";
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h00);
        bus_addr = 8'h00; step();
        bus_addr = 8'h06; step();
        bus_addr = 8'hFF; step();
        bus_addr = 8'h05; step();

        phase = "R10 override";
        alt_en = 8'h99; alt_out = 8'h8B; alt_oe = 8'hF1;
        bus_addr = 8'h01; pin_in = 8'h3E; step(3);
        alt_en = 8'hFF; alt_out = 8'hFF; alt_oe = 8'hFF; step(2);
        alt_en = 8'h00; step();

        phase = "R6 latch kept over reset";
        wr(8'h01, 8'h6E);
        rst = 1'b1; step(2); rst = 1'b0;
        bus_addr = 8'h05; step();
        wr(8'h05, 8'hFF);
        bus_addr = 8'h01; step(2);

        phase = "R1 random mix";
        for (int i = 0; i < 400; i++) begin
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_addr  = ($urandom_range(0, 3) == 0) ? 8'($urandom) :
                        (($urandom_range(0, 1) == 0) ? 8'h01 : 8'h05);
            bus_wdata = 8'($urandom);
            pin_in    = 8'($urandom);
            alt_en    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            alt_out   = 8'($urandom);
            alt_oe    = 8'($urandom);
            rst       = ($urandom_range(0, 40) == 0);
            step();
        end
        rst = 1'b0; bus_wr = 1'b0;
        step(2);
        finish_run();
    end
endmodule